// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a virtual page number after a translation-cache miss. It takes the 20-bit virtual page number, splits it into an upper 10-bit directory index and a lower 10-bit table index, and reads two 32-bit entries from memory. The first read goes to the directory whose frame number is held in the base input. The second goes to the table that the directory entry names. Both entries are checked for presence and access rights against the request's kind (read or write) and privilege (user or supervisor).

On success the walker sets the accessed bit in any entry that lacks it, and sets the dirty bit in the table entry when the access is a write. Only entries that actually change are written back to memory. All write-backs finish before a one-cycle fill pulse presents the frame number and flags for the translation cache. On failure it gives a one-cycle fault pulse with a cause code and the level that failed.

The walker is a Moore state machine with these states:
- ST_IDLE: waits for a request.
- ST_READ_DIR: directory entry read.
- ST_CHECK_DIR: directory presence test.
- ST_READ_TBL: table entry read.
- ST_CHECK_TBL: table presence and permission test, and computation of the updated entries.
- ST_UPDATE: write-back of the changed entries.
- ST_DONE: fill pulse.
- ST_FAULT: fault pulse.

These transitions are taken:
- ST_IDLE to ST_READ_DIR on an accepted request.
- ST_READ_DIR to ST_CHECK_DIR on read data.
- ST_CHECK_DIR to ST_READ_TBL when the directory entry is present, else to ST_FAULT.
- ST_READ_TBL to ST_CHECK_TBL on read data.
- ST_CHECK_TBL to ST_FAULT when the table entry is absent or access is denied.
- ST_CHECK_TBL to ST_UPDATE when an entry must change, else to ST_DONE.
- ST_UPDATE to ST_DONE after its last write is accepted.
- ST_DONE and ST_FAULT back to ST_IDLE.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is 1 only in idle. An accepted request first issues a read at address {dir_base, vpn[19:10], 2'b00}.
- R2: After a present directory entry D, the second read goes to {D[31:12], vpn[9:0], 2'b00}.
- R3: A directory entry with bit 0 (present) clear ends the walk with `fault_cause`=0 (not present) and `fault_level`=0. There is no second read and no write, whatever its other bits hold.
- R4: A table entry with bit 0 clear gives `fault_cause`=0 and `fault_level`=1, with no write to memory.
- R5: A user access (`req_user`=1) faults with `fault_cause`=2 and `fault_level`=1 unless bit 2 is set in both entries. This cause takes priority over cause 1.
- R6: A write access faults with `fault_cause`=1 and `fault_level`=1 unless bit 1 is set in both entries.
- R7: A successful walk gives a single-cycle `fill_done` with these outputs:
  - `fill_ppn` = table entry bits 31:12.
  - `fill_global` = table bit 8.
  - `fill_write` = AND of bit 1 of both entries.
  - `fill_super` = NOT of the AND of bit 2 of both entries.
  - `fill_large` = directory bit 7.
  - `fill_vpn` = the request's page number.
- R8: On success, an entry with bit 5 (accessed) clear is written back with bit 5 set. The directory entry is written before the table entry, and all writes complete before `fill_done`. An entry that needs no change is not written.
- R9: A write access sets bit 6 (dirty) in the table entry written back. A read leaves bit 6 as found. `fill_dirty` reports the resulting bit 6. A faulting walk writes nothing.
- R10: A memory request holds its valid, address, write flag and data stable until `mem_req_ready`. Read data is taken on `mem_rsp_valid` after the read is accepted.
- R11: Reset, including reset during a walk, returns the block to idle: `req_ready`=1, with no memory request and no fill or fault pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 20 | Frame number of the directory |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vpn | input | 20 | Virtual page number to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| fill_done | output | 1 | Translation ready, one cycle |
| fill_vpn | output | 20 | Page number translated |
| fill_ppn | output | 20 | Physical frame number |
| fill_global | output | 1 | Global page |
| fill_super | output | 1 | Supervisor-only page |
| fill_write | output | 1 | Page writable |
| fill_dirty | output | 1 | Page dirty after this walk |
| fill_large | output | 1 | Directory entry flags a large page |
| fault_valid | output | 1 | Walk failed, one cycle |
| fault_cause | output | 2 | 0 not present, 1 read/write, 2 user/supervisor |
| fault_level | output | 1 | 0 directory, 1 table |

## Verification
The assertions take two things for granted about the memory side:
- It returns exactly one `mem_rsp_valid` for each accepted read.
- It never returns data while no read is outstanding.

They also assume that a request arriving while the walker is busy may be dropped. The bench's memory model answers each accepted read once, a fixed one cycle later. It applies each write at acceptance. It drives `mem_req_ready` either always high or alternating, so requests are held across stalls. Requests are only raised while `req_ready` is high.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int ENT_W   = 32;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PPN_W   = ENT_W - OFF_W;
    localparam int IDX_W   = VPN_W / 2;
    localparam int BYTE_SH = OFF_W - IDX_W;

    localparam int BIT_P  = 0;
    localparam int BIT_RW = 1;
    localparam int BIT_US = 2;
    localparam int BIT_A  = 5;
    localparam int BIT_D  = 6;
    localparam int BIT_PS = 7;
    localparam int BIT_G  = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_READ_DIR, ST_CHECK_DIR, ST_READ_TBL,
        ST_CHECK_TBL, ST_UPDATE, ST_DONE, ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_ABSENT = 2'd0,
        CAUSE_RW     = 2'd1,
        CAUSE_US     = 2'd2
    } fault_cause_e;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
    import pgwalk_pkg::*;
(
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [PPN_W-1:0] dir_ppn,
    output logic [ENT_W-1:0] dir_addr,
    output logic [ENT_W-1:0] tbl_addr
);
    localparam logic [BYTE_SH-1:0] ZERO_SH = '0;

    // Directory index is the upper half of the page number, table index the lower.
    assign dir_addr = {base_ppn, vpn[VPN_W-1 -: IDX_W], ZERO_SH};
    assign tbl_addr = {dir_ppn,  vpn[IDX_W-1:0],        ZERO_SH};
endmodule

// File: rtl/pgwalk_check.sv
module pgwalk_check
    import pgwalk_pkg::*;
(
    input  logic [ENT_W-1:0] dir_ent,
    input  logic [ENT_W-1:0] tbl_ent,
    input  logic             acc_write,
    input  logic             acc_user,
    output logic             perm_ok,
    output fault_cause_e     perm_cause,
    output logic             eff_write,
    output logic             eff_user,
    output logic [ENT_W-1:0] dir_next,
    output logic [ENT_W-1:0] tbl_next,
    output logic             dir_wb,
    output logic             tbl_wb
);
    localparam logic [ENT_W-1:0] MASK_A = ENT_W'(1) << BIT_A;
    localparam logic [ENT_W-1:0] MASK_D = ENT_W'(1) << BIT_D;

    logic us_bad;
    logic rw_bad;

    always_comb begin
        eff_write  = dir_ent[BIT_RW] & tbl_ent[BIT_RW];
        eff_user   = dir_ent[BIT_US] & tbl_ent[BIT_US];
        us_bad     = acc_user  & ~eff_user;
        rw_bad     = acc_write & ~eff_write;
        perm_ok    = ~us_bad & ~rw_bad;
        // Privilege failure is reported ahead of a write-permission failure.
        perm_cause = us_bad ? CAUSE_US : CAUSE_RW;
        dir_next   = dir_ent | MASK_A;
        tbl_next   = tbl_ent | MASK_A | (acc_write ? MASK_D : '0);
        dir_wb     = ~dir_ent[BIT_A];
        tbl_wb     = ~tbl_ent[BIT_A] | (acc_write & ~tbl_ent[BIT_D]);
    end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_write,
    input  logic             req_user,
    input  logic [PPN_W-1:0] dir_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [ENT_W-1:0] mem_req_addr,
    output logic [ENT_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_rdata,
    output logic [VPN_W-1:0] vpn_o,
    output logic [PPN_W-1:0] base_o,
    output logic [ENT_W-1:0] dir_ent_o,
    output logic [ENT_W-1:0] tbl_ent_o,
    output logic             acc_write_o,
    output logic             acc_user_o,
    input  logic [ENT_W-1:0] dir_addr_i,
    input  logic [ENT_W-1:0] tbl_addr_i,
    input  logic [ENT_W-1:0] dir_next_i,
    input  logic [ENT_W-1:0] tbl_next_i,
    input  logic             dir_wb_i,
    input  logic             tbl_wb_i,
    input  logic             perm_ok_i,
    input  fault_cause_e     perm_cause_i,
    output logic             walk_done,
    output logic             walk_fault,
    output fault_cause_e     fault_cause,
    output logic             fault_level
);
    walk_state_e      state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] base_q;
    logic [ENT_W-1:0] dir_q, tbl_q;
    logic             wr_q, usr_q;
    logic             issued_q;
    logic             dir_pend_q, tbl_pend_q;
    fault_cause_e     cause_q;
    logic             level_q;
    logic             rd_back;
    logic             req_fire;

    assign rd_back  = issued_q & mem_rsp_valid;
    assign req_fire = mem_req_valid & mem_req_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_READ_DIR;
            ST_READ_DIR:  if (rd_back) state_d = ST_CHECK_DIR;
            ST_CHECK_DIR: state_d = dir_q[BIT_P] ? ST_READ_TBL : ST_FAULT;
            ST_READ_TBL:  if (rd_back) state_d = ST_CHECK_TBL;
            ST_CHECK_TBL: begin
                if (!tbl_q[BIT_P] || !perm_ok_i) state_d = ST_FAULT;
                else if (dir_wb_i || tbl_wb_i)   state_d = ST_UPDATE;
                else                             state_d = ST_DONE;
            end
            ST_UPDATE:    if (mem_req_ready && !(dir_pend_q && tbl_pend_q)) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            ST_FAULT:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Walk datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q      <= '0;
            base_q     <= '0;
            dir_q      <= '0;
            tbl_q      <= '0;
            wr_q       <= 1'b0;
            usr_q      <= 1'b0;
            issued_q   <= 1'b0;
            dir_pend_q <= 1'b0;
            tbl_pend_q <= 1'b0;
            cause_q    <= CAUSE_ABSENT;
            level_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vpn_q  <= req_vpn;
                        base_q <= dir_base;
                        wr_q   <= req_write;
                        usr_q  <= req_user;
                    end
                end
                ST_READ_DIR, ST_READ_TBL: begin
                    if (req_fire) issued_q <= 1'b1;
                    if (rd_back) begin
                        issued_q <= 1'b0;
                        if (state_q == ST_READ_DIR) dir_q <= mem_rsp_rdata;
                        else                        tbl_q <= mem_rsp_rdata;
                    end
                end
                ST_CHECK_DIR: begin
                    if (!dir_q[BIT_P]) begin
                        cause_q <= CAUSE_ABSENT;
                        level_q <= 1'b0;
                    end
                end
                ST_CHECK_TBL: begin
                    level_q <= 1'b1;
                    if (!tbl_q[BIT_P]) begin
                        cause_q <= CAUSE_ABSENT;
                    end else if (!perm_ok_i) begin
                        cause_q <= perm_cause_i;
                    end else begin
                        dir_q      <= dir_next_i;
                        tbl_q      <= tbl_next_i;
                        dir_pend_q <= dir_wb_i;
                        tbl_pend_q <= tbl_wb_i;
                    end
                end
                ST_UPDATE: begin
                    if (mem_req_ready) begin
                        if (dir_pend_q) dir_pend_q <= 1'b0;
                        else            tbl_pend_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        walk_done     = 1'b0;
        walk_fault    = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_READ_DIR: begin
                mem_req_valid = ~issued_q;
                mem_req_addr  = dir_addr_i;
            end
            ST_READ_TBL: begin
                mem_req_valid = ~issued_q;
                mem_req_addr  = tbl_addr_i;
            end
            ST_UPDATE: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dir_pend_q ? dir_addr_i : tbl_addr_i;
                mem_req_wdata = dir_pend_q ? dir_q : tbl_q;
            end
            ST_DONE:     walk_done  = 1'b1;
            ST_FAULT:    walk_fault = 1'b1;
            default: ;
        endcase
    end

    assign vpn_o       = vpn_q;
    assign base_o      = base_q;
    assign dir_ent_o   = dir_q;
    assign tbl_ent_o   = tbl_q;
    assign acc_write_o = wr_q;
    assign acc_user_o  = usr_q;
    assign fault_cause = cause_q;
    assign fault_level = level_q;

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_table_read_needs_present_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write && state_q == ST_READ_TBL |-> dir_q[BIT_P]);

    assert_wb_accessed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[BIT_A]);

    assert_dirty_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done && wr_q |-> tbl_q[BIT_D]);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    assert_fault_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_fault |=> !walk_fault && !mem_req_valid);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PPN_W-1:0] dir_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_write,
    input  logic             req_user,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [ENT_W-1:0] mem_req_addr,
    output logic [ENT_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_rdata,
    output logic             fill_done,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PPN_W-1:0] fill_ppn,
    output logic             fill_global,
    output logic             fill_super,
    output logic             fill_write,
    output logic             fill_dirty,
    output logic             fill_large,
    output logic             fault_valid,
    output logic [1:0]       fault_cause,
    output logic             fault_level
);
    logic [VPN_W-1:0] vpn_w;
    logic [PPN_W-1:0] base_w;
    logic [ENT_W-1:0] dir_ent_w, tbl_ent_w;
    logic             acc_write_w, acc_user_w;
    logic [ENT_W-1:0] dir_addr_w, tbl_addr_w;
    logic [ENT_W-1:0] dir_next_w, tbl_next_w;
    logic             dir_wb_w, tbl_wb_w, perm_ok_w;
    logic             eff_write_w, eff_user_w;
    fault_cause_e     perm_cause_w, cause_w;

    pgwalk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vpn       (req_vpn),
        .req_write     (req_write),
        .req_user      (req_user),
        .dir_base      (dir_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .vpn_o         (vpn_w),
        .base_o        (base_w),
        .dir_ent_o     (dir_ent_w),
        .tbl_ent_o     (tbl_ent_w),
        .acc_write_o   (acc_write_w),
        .acc_user_o    (acc_user_w),
        .dir_addr_i    (dir_addr_w),
        .tbl_addr_i    (tbl_addr_w),
        .dir_next_i    (dir_next_w),
        .tbl_next_i    (tbl_next_w),
        .dir_wb_i      (dir_wb_w),
        .tbl_wb_i      (tbl_wb_w),
        .perm_ok_i     (perm_ok_w),
        .perm_cause_i  (perm_cause_w),
        .walk_done     (fill_done),
        .walk_fault    (fault_valid),
        .fault_cause   (cause_w),
        .fault_level   (fault_level)
    );

    pgwalk_addr u_addr (
        .base_ppn (base_w),
        .vpn      (vpn_w),
        .dir_ppn  (dir_ent_w[ENT_W-1:OFF_W]),
        .dir_addr (dir_addr_w),
        .tbl_addr (tbl_addr_w)
    );

    pgwalk_check u_check (
        .dir_ent    (dir_ent_w),
        .tbl_ent    (tbl_ent_w),
        .acc_write  (acc_write_w),
        .acc_user   (acc_user_w),
        .perm_ok    (perm_ok_w),
        .perm_cause (perm_cause_w),
        .eff_write  (eff_write_w),
        .eff_user   (eff_user_w),
        .dir_next   (dir_next_w),
        .tbl_next   (tbl_next_w),
        .dir_wb     (dir_wb_w),
        .tbl_wb     (tbl_wb_w)
    );

    assign fault_cause = cause_w;
    assign fill_vpn    = vpn_w;
    assign fill_ppn    = tbl_ent_w[ENT_W-1:OFF_W];
    assign fill_global = tbl_ent_w[BIT_G];
    assign fill_dirty  = tbl_ent_w[BIT_D];
    assign fill_large  = dir_ent_w[BIT_PS];
    assign fill_write  = eff_write_w;
    assign fill_super  = ~eff_user_w;
endmodule

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        us;
        logic [31:0] pde;
        logic [31:0] pte;
        logic        flt;
        logic [1:0]  cause;
        logic        lvl;
        logic [1:0]  nwr;
        logic [31:0] mpde;
        logic [31:0] mpte;
        logic [19:0] ppn;
        logic        g;
        logic        w;
        logic        s;
        logic        d;
        logic        big;
    } vec_t;

    localparam int NV = 11;
    localparam logic [19:0] BASE = 20'h00010;
    localparam vec_t VECS [NV] = '{
        '{32'h00403123,1'b0,1'b0,32'h00020007,32'h12345027,1'b0,2'd0,1'b0,2'd1,32'h00020027,32'h12345027,20'h12345,1'b0,1'b1,1'b0,1'b0,1'b0},
        '{32'h00805ABC,1'b1,1'b1,32'h00021027,32'h0ABCD107,1'b0,2'd0,1'b0,2'd1,32'h00021027,32'h0ABCD167,20'h0ABCD,1'b1,1'b1,1'b0,1'b1,1'b0},
        '{32'h00C07000,1'b1,1'b0,32'h000220A7,32'h55555067,1'b0,2'd0,1'b0,2'd0,32'h000220A7,32'h55555067,20'h55555,1'b0,1'b1,1'b0,1'b1,1'b1},
        '{32'h01001000,1'b0,1'b0,32'hFFFFFFFE,32'h00000000,1'b1,2'd0,1'b0,2'd0,32'hFFFFFFFE,32'h00000000,20'h0,1'b0,1'b0,1'b0,1'b0,1'b0},
        '{32'h01402000,1'b0,1'b0,32'h00023007,32'h000000E6,1'b1,2'd0,1'b1,2'd0,32'h00023007,32'h000000E6,20'h0,1'b0,1'b0,1'b0,1'b0,1'b0},
        '{32'h01803000,1'b0,1'b1,32'h00024003,32'h66666007,1'b1,2'd2,1'b1,2'd0,32'h00024003,32'h66666007,20'h0,1'b0,1'b0,1'b0,1'b0,1'b0},
        '{32'h01C04000,1'b1,1'b0,32'h00025007,32'h77777005,1'b1,2'd1,1'b1,2'd0,32'h00025007,32'h77777005,20'h0,1'b0,1'b0,1'b0,1'b0,1'b0},
        '{32'h02005000,1'b1,1'b1,32'h00026001,32'h11111001,1'b1,2'd2,1'b1,2'd0,32'h00026001,32'h11111001,20'h0,1'b0,1'b0,1'b0,1'b0,1'b0},
        '{32'h02406000,1'b0,1'b0,32'h00027001,32'h22222001,1'b0,2'd0,1'b0,2'd2,32'h00027021,32'h22222021,20'h22222,1'b0,1'b0,1'b1,1'b0,1'b0},
        '{32'h02807000,1'b1,1'b0,32'h00028025,32'h33333027,1'b1,2'd1,1'b1,2'd0,32'h00028025,32'h33333027,20'h0,1'b0,1'b0,1'b0,1'b0,1'b0},
        '{32'h02C08000,1'b0,1'b0,32'h00029027,32'h44444067,1'b0,2'd0,1'b0,2'd0,32'h00029027,32'h44444067,20'h44444,1'b0,1'b1,1'b0,1'b1,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] dir_base = BASE;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        fill_done;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic        fill_global, fill_super, fill_write, fill_dirty, fill_large;
    logic        fault_valid;
    logic [1:0]  fault_cause;
    logic        fault_level;

    pgwalk_top u_pgwalk_top (.*);

    // 50 MHz: 20 time-unit period
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit stall = 1'b0;

    logic [31:0] mem [logic [31:0]];
    logic        fire_q = 1'b0;
    logic        fw_q = 1'b0;
    logic [31:0] fa_q = '0;
    logic [31:0] fd_q = '0;
    int          nwr = 0;
    int          nrd = 0;
    logic [31:0] rd_addr0, rd_addr1, wr_addr0;
    int          cyc = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // capture accepted memory requests at the active edge
    initial forever begin
        @(posedge clk);
        fire_q <= mem_req_valid && mem_req_ready;
        fw_q   <= mem_req_write;
        fa_q   <= mem_req_addr;
        fd_q   <= mem_req_wdata;
    end

    // memory model: acts on the falling edge
    initial forever begin
        @(negedge clk);
        cyc++;
        mem_rsp_valid = 1'b0;
        mem_req_ready = stall ? cyc[0] : 1'b1;
        if (fire_q) begin
            if (fw_q) begin
                mem[fa_q] = fd_q;
                if (nwr == 0) wr_addr0 = fa_q;
                nwr++;
            end else begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mem.exists(fa_q) ? mem[fa_q] : 32'h0;
                if (nrd == 0) rd_addr0 = fa_q;
                else          rd_addr1 = fa_q;
                nrd++;
            end
        end
    end

    task automatic run_vec(input vec_t v);
        logic [31:0] pa, ta;
        bit got_done, got_fault;
        logic [19:0] o_ppn, o_vpn;
        logic o_g, o_w, o_s, o_d, o_big, o_lvl;
        logic [1:0] o_cause;
        string ftag;
        pa = {BASE, v.va[31:22], 2'b00};
        ta = {v.pde[31:12], v.va[21:12], 2'b00};
        mem[pa] = v.pde;
        if (v.pde[0]) mem[ta] = v.pte;
        @(negedge clk);
        nwr = 0; nrd = 0;
        req_vpn = v.va[31:12]; req_write = v.wr; req_user = v.us; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 1'b0; got_fault = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (fill_done || fault_valid) break;
            @(negedge clk);
        end
        got_done = fill_done; got_fault = fault_valid;
        o_ppn = fill_ppn; o_vpn = fill_vpn; o_g = fill_global; o_w = fill_write;
        o_s = fill_super; o_d = fill_dirty; o_big = fill_large;
        o_cause = fault_cause; o_lvl = fault_level;
        @(negedge clk);
        chk("R1", "first read address", rd_addr0, pa);
        chk("R3", "read count", 32'(nrd), v.pde[0] ? 32'd2 : 32'd1);
        if (v.pde[0]) chk("R2", "second read address", rd_addr1, ta);
        if (v.flt) begin
            if (v.lvl == 1'b0)         ftag = "R3";
            else if (v.cause == 2'd0)  ftag = "R4";
            else if (v.cause == 2'd2)  ftag = "R5";
            else                       ftag = "R6";
            chk(ftag, "fault pulse", {31'b0, got_fault}, 32'd1);
            chk(ftag, "fault cause", {30'b0, o_cause}, {30'b0, v.cause});
            chk(ftag, "fault level", {31'b0, o_lvl}, {31'b0, v.lvl});
            chk("R9", "no write on fault", 32'(nwr), 32'd0);
        end else begin
            chk("R7", "fill pulse", {31'b0, got_done}, 32'd1);
            chk("R7", "fill ppn", {12'b0, o_ppn}, {12'b0, v.ppn});
            chk("R7", "fill vpn", {12'b0, o_vpn}, {12'b0, v.va[31:12]});
            chk("R7", "fill flags g,w,s,big", {28'b0, o_g, o_w, o_s, o_big}, {28'b0, v.g, v.w, v.s, v.big});
            chk("R9", "fill dirty", {31'b0, o_d}, {31'b0, v.d});
            chk("R8", "write count", 32'(nwr), {30'b0, v.nwr});
            chk("R8", "directory entry in memory", mem[pa], v.mpde);
            chk("R9", "table entry in memory", mem[ta], v.mpte);
            if (v.nwr == 2'd2) chk("R8", "directory written first", wr_addr0, pa);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset ready", {31'b0, req_ready}, 32'd1);
        chk("R11", "reset mem valid", {31'b0, mem_req_valid}, 32'd0);
        chk("R11", "reset pulses", {30'b0, fill_done, fault_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "idle ready after reset", {31'b0, req_ready}, 32'd1);

        for (int pass = 0; pass < 2; pass++) begin
            stall = (pass == 1);   // pass 1 exercises R10 stalls
            for (int k = 0; k < NV; k++) run_vec(VECS[k]);
        end
        stall = 1'b0;

        // Directed: reset in the middle of a walk (R11)
        mem[{BASE, 10'd12, 2'b00}] = 32'h0002A007;
        req_vpn = {10'd12, 10'd1}; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "busy after accept", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "mid-walk reset ready", {31'b0, req_ready}, 32'd1);
        chk("R11", "mid-walk reset mem valid", {31'b0, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_vec(VECS[0]);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule